// File: doc/BRIEF.md
# Two-Level Microcoded Control Sequencer

This block is the control unit of a multi-cycle processor. A micro-program counter selects one step of the current instruction's micro-program. Control words are not kept flat per micro-address. A first lookup turns the micro-address into a narrow operation code, and each code names one register transfer or a fixed group of transfers. A second lookup expands that code into the full set of datapath control lines. Several micro-addresses that perform the same transfer share one expansion entry.

Next-address information sits in its own small table beside the first lookup. Each micro-address picks one of three moves: step to the next address, jump to the entry point for the instruction opcode presented by the datapath, or return to the fetch step. Both lookup levels and the sequencing table are constant tables built into the logic. The control outputs are combinational from the micro-PC register.

Top module: `ucode_ctrl_top`

## Requirements
- R1: While `rst` is high at a rising edge, `upc` becomes 0 (the fetch step) at that edge.
- R2: At micro-address 0 the next micro-address is always 1 (the decode step).
- R3: At micro-address 1 the next micro-address depends on `opcode` sampled at that edge: 6'h23 goes to 2, 6'h2B goes to 5, 6'h00 goes to 7, 6'h04 goes to 9, 6'h02 goes to 10.
- R4: At micro-address 1, any opcode not listed in R3 makes the next micro-address 0.
- R5: Micro-addresses 2, 3, 5 and 7 step to the following address. Micro-addresses 4, 6, 8, 9 and 10 return to 0. This gives the paths 0,1,2,3,4 / 0,1,5,6 / 0,1,7,8 / 0,1,9 / 0,1,10.
- R6: `opcode` has no effect on the next micro-address when `upc` is any value other than 1.
- R7: `op_code` per micro-address 0..10 is 1,2,3,4,5,3,6,7,8,9,10 respectively.
- R8: `ctrl` bit layout, MSB first: [15] PC write, [14] PC write when ALU zero, [13] memory address from ALU result, [12] memory read, [11] memory write, [10] instruction register load, [9] write-back from memory data, [8] destination from rd field, [7] register file write, [6] ALU A from register, [5:4] ALU B select, [3:2] ALU function, [1:0] next-PC source (2 = upper PC bits joined with a 26-bit target and two zero bits). The words for op codes 1..10 are 9410, 0030, 0060, 3000, 0280, 2800, 0048, 0180, 4045, 8002 (hex), and op code 0 gives 0000.
- R9: Memory read and memory write are never both set, and PC write and conditional PC write are never both set.
- R10: Micro-addresses 2 and 5 give the same `op_code` (3) and the same `ctrl` word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Instruction opcode from the instruction register |
| upc | output | 4 | Current micro-program counter |
| op_code | output | 4 | First-level lookup result for `upc` |
| ctrl | output | 16 | Expanded datapath control word |

## Verification
The micro-PC is the only register, so a new `upc` appears one edge after the `opcode` or `rst` value that selects it. `op_code` and `ctrl` follow `upc` combinationally within the same cycle. The bench drives inputs on falling edges. It reads all three outputs on the falling edge after each rising edge, so each check looks at the state exactly one edge after its stimulus. On every step the expanded word is compared with a flat per-address reference table. Off-decode steps drive a misleading opcode to show that it is ignored.

// File: rtl/ucode_pkg.sv
package ucode_pkg;

    localparam int UPC_W   = 4;
    localparam int OP_W    = 4;
    localparam int OPC_W   = 6;
    localparam int UPC_DEP = 1 << UPC_W;
    localparam int OP_DEP  = 1 << OP_W;

    typedef enum logic [1:0] {
        NXT_INC      = 2'd0,
        NXT_DISPATCH = 2'd1,
        NXT_FETCH    = 2'd2
    } nxt_sel_e;

    typedef enum logic [OP_W-1:0] {
        RT_NOP      = 4'd0,
        RT_FETCH    = 4'd1,
        RT_DECODE   = 4'd2,
        RT_ADDR     = 4'd3,
        RT_MEM_RD   = 4'd4,
        RT_LOAD_WB  = 4'd5,
        RT_MEM_WR   = 4'd6,
        RT_ALU_EXE  = 4'd7,
        RT_ALU_WB   = 4'd8,
        RT_BRANCH   = 4'd9,
        RT_JUMP     = 4'd10
    } rt_op_e;

    typedef struct packed {
        logic       pc_wr;
        logic       pc_wr_if_zero;
        logic       addr_from_alu;
        logic       rd_mem;
        logic       wr_mem;
        logic       ir_load;
        logic       wb_from_mem;
        logic       dst_is_rd;
        logic       rf_wr;
        logic       alu_a_is_reg;
        logic [1:0] alu_b_sel;
        logic [1:0] alu_func;
        logic [1:0] pc_next_sel;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    // micro-program entry points
    localparam logic [UPC_W-1:0] UA_FETCH    = 4'd0;
    localparam logic [UPC_W-1:0] UA_DECODE   = 4'd1;
    localparam logic [UPC_W-1:0] UA_LD_ADDR  = 4'd2;
    localparam logic [UPC_W-1:0] UA_LD_READ  = 4'd3;
    localparam logic [UPC_W-1:0] UA_LD_WB    = 4'd4;
    localparam logic [UPC_W-1:0] UA_ST_ADDR  = 4'd5;
    localparam logic [UPC_W-1:0] UA_ST_WRITE = 4'd6;
    localparam logic [UPC_W-1:0] UA_RR_EXE   = 4'd7;
    localparam logic [UPC_W-1:0] UA_RR_WB    = 4'd8;
    localparam logic [UPC_W-1:0] UA_BR       = 4'd9;
    localparam logic [UPC_W-1:0] UA_JMP      = 4'd10;

    // instruction opcodes decoded by the dispatch step
    localparam logic [OPC_W-1:0] OPC_RR   = 6'h00;
    localparam logic [OPC_W-1:0] OPC_JMP  = 6'h02;
    localparam logic [OPC_W-1:0] OPC_BR   = 6'h04;
    localparam logic [OPC_W-1:0] OPC_LOAD = 6'h23;
    localparam logic [OPC_W-1:0] OPC_STOR = 6'h2B;

    // first level: micro-address to transfer code
    function automatic rt_op_e op_of_upc(input logic [UPC_W-1:0] a);
        case (a)
            UA_FETCH:    return RT_FETCH;
            UA_DECODE:   return RT_DECODE;
            UA_LD_ADDR:  return RT_ADDR;
            UA_LD_READ:  return RT_MEM_RD;
            UA_LD_WB:    return RT_LOAD_WB;
            UA_ST_ADDR:  return RT_ADDR;
            UA_ST_WRITE: return RT_MEM_WR;
            UA_RR_EXE:   return RT_ALU_EXE;
            UA_RR_WB:    return RT_ALU_WB;
            UA_BR:       return RT_BRANCH;
            UA_JMP:      return RT_JUMP;
            default:     return RT_NOP;
        endcase
    endfunction

    // sequencing table, kept apart from the control stores
    function automatic nxt_sel_e nxt_of_upc(input logic [UPC_W-1:0] a);
        case (a)
            UA_FETCH, UA_LD_ADDR, UA_LD_READ,
            UA_ST_ADDR, UA_RR_EXE:           return NXT_INC;
            UA_DECODE:                       return NXT_DISPATCH;
            default:                         return NXT_FETCH;
        endcase
    endfunction

    // dispatch table: opcode to first micro-address of its routine
    function automatic logic [UPC_W-1:0] dispatch_upc(input logic [OPC_W-1:0] opc);
        case (opc)
            OPC_LOAD: return UA_LD_ADDR;
            OPC_STOR: return UA_ST_ADDR;
            OPC_RR:   return UA_RR_EXE;
            OPC_BR:   return UA_BR;
            OPC_JMP:  return UA_JMP;
            default:  return UA_FETCH;
        endcase
    endfunction

    // second level: transfer code to control lines
    function automatic ctrl_t expand_op(input logic [OP_W-1:0] c);
        ctrl_t w;
        w = '0;
        case (c)
            RT_FETCH: begin         // IR <- MEM[PC], PC <- PC + 4
                w.rd_mem    = 1'b1;
                w.ir_load   = 1'b1;
                w.alu_b_sel = 2'd1;
                w.pc_wr     = 1'b1;
            end
            RT_DECODE: begin        // A, B <- RF ; ALUOut <- PC + offset
                w.alu_b_sel = 2'd3;
            end
            RT_ADDR: begin          // ALUOut <- A + imm
                w.alu_a_is_reg = 1'b1;
                w.alu_b_sel    = 2'd2;
            end
            RT_MEM_RD: begin        // MDR <- MEM[ALUOut]
                w.rd_mem        = 1'b1;
                w.addr_from_alu = 1'b1;
            end
            RT_LOAD_WB: begin       // RF[rt] <- MDR
                w.rf_wr       = 1'b1;
                w.wb_from_mem = 1'b1;
            end
            RT_MEM_WR: begin        // MEM[ALUOut] <- B
                w.wr_mem        = 1'b1;
                w.addr_from_alu = 1'b1;
            end
            RT_ALU_EXE: begin       // ALUOut <- A func B
                w.alu_a_is_reg = 1'b1;
                w.alu_func     = 2'd2;
            end
            RT_ALU_WB: begin        // RF[rd] <- ALUOut
                w.rf_wr     = 1'b1;
                w.dst_is_rd = 1'b1;
            end
            RT_BRANCH: begin        // if A == B then PC <- ALUOut
                w.alu_a_is_reg  = 1'b1;
                w.alu_func      = 2'd1;
                w.pc_wr_if_zero = 1'b1;
                w.pc_next_sel   = 2'd1;
            end
            RT_JUMP: begin          // PC <- {PC upper, target, 2'b00}
                w.pc_wr       = 1'b1;
                w.pc_next_sel = 2'd2;
            end
            default: w = '0;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/ucode_op_store.sv
module ucode_op_store
    import ucode_pkg::*;
#(
    parameter int AW = UPC_W,
    localparam int DEP = 1 << AW
) (
    input  logic [AW-1:0] upc,
    output rt_op_e        op
);
    rt_op_e rom [DEP];

    for (genvar g = 0; g < DEP; g++) begin : g_row
        assign rom[g] = op_of_upc(UPC_W'(g));
    end

    assign op = rom[upc];
endmodule

// File: rtl/ucode_ctl_store.sv
module ucode_ctl_store
    import ucode_pkg::*;
#(
    parameter int CW = OP_W,
    localparam int DEP = 1 << CW
) (
    input  logic [CW-1:0] op,
    output ctrl_t         ctrl
);
    ctrl_t rom [DEP];

    for (genvar g = 0; g < DEP; g++) begin : g_row
        assign rom[g] = expand_op(OP_W'(g));
    end

    assign ctrl = rom[op];
endmodule

// File: rtl/ucode_seq.sv
module ucode_seq
    import ucode_pkg::*;
#(
    parameter int AW = UPC_W,
    localparam int DEP = 1 << AW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [OPC_W-1:0] opcode,
    output logic [AW-1:0]    upc
);
    nxt_sel_e    nxt_tbl [DEP];
    nxt_sel_e    nxt;
    logic [AW-1:0] upc_d;

    for (genvar g = 0; g < DEP; g++) begin : g_nxt
        assign nxt_tbl[g] = nxt_of_upc(UPC_W'(g));
    end

    assign nxt = nxt_tbl[upc];

    always_comb begin
        case (nxt)
            NXT_INC:      upc_d = upc + 1'b1;
            NXT_DISPATCH: upc_d = dispatch_upc(opcode);
            default:      upc_d = UA_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) upc <= UA_FETCH;
        else     upc <= upc_d;
    end

    AST_RESET_TO_FETCH: assert property (@(posedge clk)
        rst |=> (upc == UA_FETCH));                                   // R1
    AST_FETCH_THEN_DECODE: assert property (@(posedge clk) disable iff (rst)
        (upc == UA_FETCH) |=> (upc == UA_DECODE));                    // R2
    AST_LOAD_DISPATCH: assert property (@(posedge clk) disable iff (rst)
        (upc == UA_DECODE && opcode == OPC_LOAD) |=> (upc == UA_LD_ADDR)); // R3
    AST_STEP_INC: assert property (@(posedge clk) disable iff (rst)
        (nxt == NXT_INC) |=> (upc == $past(upc) + 1'b1));             // R5
    AST_RETURN_FETCH: assert property (@(posedge clk) disable iff (rst)
        (nxt == NXT_FETCH) |=> (upc == UA_FETCH));                    // R5
    AST_OPC_OFF_DECODE: assert property (@(posedge clk) disable iff (rst)
        (upc != UA_DECODE) |=> (upc == UA_FETCH || upc == $past(upc) + 1'b1)); // R6
endmodule

// File: rtl/ucode_ctrl_top.sv
module ucode_ctrl_top
    import ucode_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [OPC_W-1:0]  opcode,
    output logic [UPC_W-1:0]  upc,
    output logic [OP_W-1:0]   op_code,
    output logic [CTRL_W-1:0] ctrl
);
    rt_op_e op_s;
    ctrl_t  ctrl_s;

    ucode_seq #(.AW(UPC_W)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .opcode (opcode),
        .upc    (upc)
    );

    ucode_op_store #(.AW(UPC_W)) u_lvl1 (
        .upc (upc),
        .op  (op_s)
    );

    ucode_ctl_store #(.CW(OP_W)) u_lvl2 (
        .op   (op_s),
        .ctrl (ctrl_s)
    );

    assign op_code = op_s;
    assign ctrl    = ctrl_s;

    AST_MEM_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(ctrl_s.rd_mem && ctrl_s.wr_mem));                           // R9
    AST_PCWR_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ctrl_s.pc_wr, ctrl_s.pc_wr_if_zero}));              // R9
    AST_SHARED_ADDR: assert property (@(posedge clk) disable iff (rst)
        (upc == UA_LD_ADDR || upc == UA_ST_ADDR) |-> (op_s == RT_ADDR)); // R10
    AST_FETCH_WORD: assert property (@(posedge clk) disable iff (rst)
        (upc == UA_FETCH) |-> (ctrl_s.ir_load && ctrl_s.pc_wr));      // R8
endmodule

// File: tb/sim_ucode_ctrl_top.sv
module sim_ucode_ctrl_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  opcode = 6'h00;
    logic [3:0]  upc;
    logic [3:0]  op_code;
    logic [15:0] ctrl;
    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;   // 125 MHz

    ucode_ctrl_top u0 (
        .clk(clk), .rst(rst), .opcode(opcode),
        .upc(upc), .op_code(op_code), .ctrl(ctrl)
    );

    // R7 reference: first-level codes per micro-address
    function automatic logic [3:0] exp_op(input logic [3:0] a);
        case (a)
            4'd0: return 4'd1;  4'd1: return 4'd2;  4'd2: return 4'd3;
            4'd3: return 4'd4;  4'd4: return 4'd5;  4'd5: return 4'd3;
            4'd6: return 4'd6;  4'd7: return 4'd7;  4'd8: return 4'd8;
            4'd9: return 4'd9;  4'd10: return 4'd10;
            default: return 4'd0;
        endcase
    endfunction

    // R8 flat reference: full control word per micro-address
    function automatic logic [15:0] flat_ctrl(input logic [3:0] a);
        case (a)
            4'd0: return 16'h9410;  4'd1: return 16'h0030;
            4'd2: return 16'h0060;  4'd3: return 16'h3000;
            4'd4: return 16'h0280;  4'd5: return 16'h0060;
            4'd6: return 16'h2800;  4'd7: return 16'h0048;
            4'd8: return 16'h0180;  4'd9: return 16'h4045;
            4'd10: return 16'h8002;
            default: return 16'h0000;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_outputs(input logic [3:0] a);
        chk("R7 op_code", {28'd0, op_code}, {28'd0, exp_op(a)});
        chk("R8 ctrl", {16'd0, ctrl}, {16'd0, flat_ctrl(a)});
        chk("R9 exclusive", {31'd0, (ctrl[12] & ctrl[11]) | (ctrl[15] & ctrl[14])}, 32'd0);
    endtask

    // walk one instruction; off-decode steps drive a distracting opcode (R6)
    task automatic walk(input string name, input logic [5:0] opc, input int len,
                        input logic [4:0][3:0] path);
        for (int i = 0; i < len; i++) begin
            if (i == 2) chk({"R3 dispatch ", name}, {28'd0, upc}, {28'd0, path[4-i]});
            else        chk({"R5 path ", name}, {28'd0, upc}, {28'd0, path[4-i]});
            chk_outputs(path[4-i]);
            opcode = (upc == 4'd1) ? opc : ((opc == 6'h02) ? 6'h23 : 6'h02);
            @(posedge clk); @(negedge clk);
        end
        chk({"R5 return ", name}, {28'd0, upc}, 32'd0);
    endtask

    task automatic t_reset();
        rst = 1'b1; opcode = 6'h23;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset upc", {28'd0, upc}, 32'd0);
        chk_outputs(4'd0);
        rst = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R2 fetch to decode", {28'd0, upc}, 32'd1);
        opcode = 6'h3F;
        @(posedge clk); @(negedge clk);
        chk("R4 unknown opcode", {28'd0, upc}, 32'd0);
    endtask

    task automatic t_mid_reset();
        opcode = 6'h02;
        @(posedge clk); @(negedge clk);            // upc 1
        opcode = 6'h23;
        @(posedge clk); @(negedge clk);            // upc 2
        @(posedge clk); @(negedge clk);            // upc 3
        chk("R5 load step", {28'd0, upc}, 32'd3);
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R1 reset mid-routine", {28'd0, upc}, 32'd0);
        rst = 1'b0;
    endtask

    task automatic t_shared();
        opcode = 6'h23;
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk);            // upc 2
        chk("R10 load addr op", {28'd0, op_code}, 32'd3);
        chk("R10 load addr ctrl", {16'd0, ctrl}, 32'h0060);
        rst = 1'b1; @(posedge clk); @(negedge clk); rst = 1'b0;
        opcode = 6'h2B;
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk);            // upc 5
        chk("R10 store addr op", {28'd0, op_code}, 32'd3);
        chk("R10 store addr ctrl", {16'd0, ctrl}, 32'h0060);
        rst = 1'b1; @(posedge clk); @(negedge clk); rst = 1'b0;
    endtask

    initial begin
        t_reset();
        walk("load",    6'h23, 5, {4'd0, 4'd1, 4'd2, 4'd3, 4'd4});
        walk("store",   6'h2B, 4, {4'd0, 4'd1, 4'd5, 4'd6, 4'd0});
        walk("reg-reg", 6'h00, 4, {4'd0, 4'd1, 4'd7, 4'd8, 4'd0});
        walk("branch",  6'h04, 3, {4'd0, 4'd1, 4'd9, 4'd0, 4'd0});
        walk("jump",    6'h02, 3, {4'd0, 4'd1, 4'd10, 4'd0, 4'd0});
        walk("unknown", 6'h11, 2, {4'd0, 4'd1, 4'd0, 4'd0, 4'd0});   // R4
        t_mid_reset();
        t_shared();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule